// File: doc/BRIEF.md
# External Status Interrupt Latch

This block gathers four status conditions of a serial channel into one status byte and drives a single external/status interrupt request. The four conditions are a line break or frame abort, a transmit underrun / end-of-message latch, the clear-to-send pin and the sync/hunt input. Each condition has its own enable, and each follows its own rule for which changes call for service.

While the request is pending, the latched bits hold still, so software reads a consistent snapshot. The register-file logic around the block supplies the enables and three single-cycle command strobes. The release command drops the request and reopens the latches on the current levels. Any change that happened while the request was pending and still needs service raises the request again at once.

Top module: `xstat_latch`

## Requirements
- R1: After reset the status byte reads 0x40 (only the underrun bit set) and the interrupt request is low.
- R2: Bits 3..0 of the status byte always read 0. While the request is pending and a pin's enable is on, its bit (5 for clear-to-send, 4 for sync/hunt) holds the value latched when the request rose.
- R3: Bit 7 shows the live break/abort level. With its enable on, a rise or a fall raises the request. A change that arrives while the request is pending, or in the cycle of the release command, raises the request again on release.
- R4: Bit 6 becomes 1 on an underrun pulse, on a send-abort strobe or while the transmitter is disabled. It becomes 0 only on the underrun-clear strobe, and a set strobe wins over a clear strobe in the same cycle.
- R5: With its enable on, only a 0-to-1 change of bit 6 raises the request, one cycle after the bit is set. A 1-to-0 change raises nothing.
- R6: With its enable on and no request pending, a change on the clear-to-send or sync pin latches the new level into its bit and raises the request after the same clock edge.
- R7: On release, a pin that changed an odd number of times while the request was pending raises the request again, and its bit shows the current level. An even number of changes raises nothing.
- R8: With its enable off, bit 5 or bit 4 shows the live pin level and never raises the request.
- R9: With both the asynchronous-mode input and the crystal-select input high, bit 4 reads 0 and sync changes raise no request.
- R10: The request stays high until the release command. A release command while nothing is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| brk_lvl_i | input | 1 | Break/abort condition level from the receiver |
| tx_en_i | input | 1 | Transmitter enabled; low holds the underrun bit set |
| tx_urun_i | input | 1 | One-cycle transmit underrun pulse |
| cts_pin_i | input | 1 | Clear-to-send pin level |
| sync_pin_i | input | 1 | Sync/hunt condition level |
| async_mode_i | input | 1 | Channel is in asynchronous mode |
| xtal_sel_i | input | 1 | Crystal oscillator option selected |
| ie_brk_i | input | 1 | Break/abort interrupt enable |
| ie_urun_i | input | 1 | Underrun interrupt enable |
| ie_cts_i | input | 1 | Clear-to-send interrupt enable and latch select |
| ie_sync_i | input | 1 | Sync/hunt interrupt enable and latch select |
| cmd_es_clr_i | input | 1 | Release command strobe |
| cmd_urun_clr_i | input | 1 | Underrun-clear command strobe |
| cmd_abort_i | input | 1 | Send-abort command strobe |
| stat_o | output | 8 | Status byte: 7 break, 6 underrun, 5 clear-to-send, 4 sync, 3..0 zero |
| irq_o | output | 1 | External/status interrupt request |

## Verification
A new condition edge can land in the same cycle as the release command. That edge must not be lost, and where it completes an even count of toggles it must cancel the pending one. The bench drives a break fall together with the release strobe and expects the request to stay high. It also drives a send-abort together with an underrun clear and expects bit 6 to stay set with no new request. The pin parity cases are judged after three toggles and after two toggles, by the request level and the byte read right after release.

// File: rtl/xstat_pkg.sv
package xstat_pkg;
    localparam int STAT_W   = 8;
    localparam int BIT_BRK  = 7;
    localparam int BIT_URUN = 6;
    localparam int BIT_CTS  = 5;
    localparam int BIT_SYNC = 4;
    localparam int NUM_SRC  = 4;

    typedef struct packed {
        logic prev;
        logic lat;
        logic tog;
    } track_t;

    typedef struct packed {
        logic prev;
        logic owe;
    } owe_t;

    typedef struct packed {
        logic irq;
    } top_t;
endpackage

// File: rtl/xstat_track.sv
module xstat_track
    import xstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic en_i,
    input  logic force0_i,
    input  logic pend_i,
    input  logic rel_i,
    output logic show_o,
    output logic evt_o
);
    track_t r_d, r_q;
    logic   chg_s;
    logic   raw_evt;

    always_comb begin
        r_d      = r_q;
        chg_s    = pin_i ^ r_q.prev;
        r_d.prev = pin_i;
        raw_evt  = 1'b0;
        if (!pend_i) begin
            r_d.lat = pin_i;
            r_d.tog = 1'b0;
            raw_evt = chg_s;
        end else if (rel_i) begin
            r_d.lat = pin_i;
            r_d.tog = 1'b0;
            raw_evt = r_q.tog ^ chg_s;
        end else begin
            r_d.tog = r_q.tog ^ chg_s;
        end
        evt_o  = raw_evt & en_i & ~force0_i;
        show_o = force0_i ? 1'b0 : (en_i ? r_q.lat : pin_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/xstat_edge.sv
module xstat_edge
    import xstat_pkg::*;
#(
    parameter bit BOTH_EDGES = 1'b1,
    parameter bit RST_LVL    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic en_i,
    input  logic pend_i,
    input  logic rel_i,
    output logic evt_o
);
    owe_t r_d, r_q;
    logic chg_s;
    logic hit_s;

    generate
        if (BOTH_EDGES) begin : g_both
            assign chg_s = lvl_i ^ r_q.prev;
        end else begin : g_rise
            assign chg_s = lvl_i & ~r_q.prev;
        end
    endgenerate

    always_comb begin
        r_d      = r_q;
        r_d.prev = lvl_i;
        hit_s    = chg_s & en_i;
        evt_o    = 1'b0;
        if (!pend_i) begin
            evt_o   = hit_s;
            r_d.owe = 1'b0;
        end else if (rel_i) begin
            evt_o   = r_q.owe | hit_s;
            r_d.owe = 1'b0;
        end else begin
            r_d.owe = r_q.owe | hit_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.prev <= RST_LVL;
            r_q.owe  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/xstat_urun.sv
module xstat_urun (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic tx_urun_i,
    input  logic abort_i,
    input  logic clr_i,
    output logic urun_o
);
    logic urun_d, urun_q;
    logic set_s;

    always_comb begin
        set_s  = ~tx_en_i | tx_urun_i | abort_i;
        urun_d = urun_q;
        if (set_s)      urun_d = 1'b1;
        else if (clr_i) urun_d = 1'b0;
        urun_o = urun_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) urun_q <= 1'b1;
        else        urun_q <= urun_d;
    end
endmodule

// File: rtl/xstat_latch.sv
module xstat_latch
    import xstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_lvl_i,
    input  logic              tx_en_i,
    input  logic              tx_urun_i,
    input  logic              cts_pin_i,
    input  logic              sync_pin_i,
    input  logic              async_mode_i,
    input  logic              xtal_sel_i,
    input  logic              ie_brk_i,
    input  logic              ie_urun_i,
    input  logic              ie_cts_i,
    input  logic              ie_sync_i,
    input  logic              cmd_es_clr_i,
    input  logic              cmd_urun_clr_i,
    input  logic              cmd_abort_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_o
);
    top_t               s_d, s_q;
    logic               rel_s;
    logic               force0_s;
    logic               urun_s;
    logic               cts_show, sync_show;
    logic [NUM_SRC-1:0] evt_s;

    assign rel_s    = cmd_es_clr_i & s_q.irq;
    assign force0_s = async_mode_i & xtal_sel_i;

    xstat_urun u_urun (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en_i   (tx_en_i),
        .tx_urun_i (tx_urun_i),
        .abort_i   (cmd_abort_i),
        .clr_i     (cmd_urun_clr_i),
        .urun_o    (urun_s)
    );

    xstat_edge #(.BOTH_EDGES(1'b1), .RST_LVL(1'b0)) u_brk (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (brk_lvl_i),
        .en_i   (ie_brk_i),
        .pend_i (s_q.irq),
        .rel_i  (rel_s),
        .evt_o  (evt_s[3])
    );

    xstat_edge #(.BOTH_EDGES(1'b0), .RST_LVL(1'b1)) u_uedge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (urun_s),
        .en_i   (ie_urun_i),
        .pend_i (s_q.irq),
        .rel_i  (rel_s),
        .evt_o  (evt_s[2])
    );

    xstat_track u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (cts_pin_i),
        .en_i     (ie_cts_i),
        .force0_i (1'b0),
        .pend_i   (s_q.irq),
        .rel_i    (rel_s),
        .show_o   (cts_show),
        .evt_o    (evt_s[1])
    );

    xstat_track u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (sync_pin_i),
        .en_i     (ie_sync_i),
        .force0_i (force0_s),
        .pend_i   (s_q.irq),
        .rel_i    (rel_s),
        .show_o   (sync_show),
        .evt_o    (evt_s[0])
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = (s_q.irq & ~rel_s) | (|evt_s);
        stat_o            = '0;
        stat_o[BIT_BRK]   = brk_lvl_i;
        stat_o[BIT_URUN]  = urun_s;
        stat_o[BIT_CTS]   = cts_show;
        stat_o[BIT_SYNC]  = sync_show;
        irq_o             = s_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/xstat_chk.sv
module xstat_chk
    import xstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ie_cts_i,
    input logic              async_mode_i,
    input logic              xtal_sel_i,
    input logic              cmd_es_clr_i,
    input logic              cmd_urun_clr_i,
    input logic [STAT_W-1:0] stat_o,
    input logic              irq_o
);
    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !cmd_es_clr_i) |=> irq_o);

    // R4
    urun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o[BIT_URUN]) |-> $past(cmd_urun_clr_i));

    // R2
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[3:0] == 4'b0000);

    // R2
    cts_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o) && !$past(cmd_es_clr_i) && ie_cts_i && $past(ie_cts_i))
        |-> $stable(stat_o[BIT_CTS]));

    // R9
    sync_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode_i && xtal_sel_i) |-> !stat_o[BIT_SYNC]);
endmodule

bind xstat_latch xstat_chk u_chk (.*);

// File: tb/sim_xstat_latch.sv
`timescale 1ns/1ps
module sim_xstat_latch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic brk = 0, tx_en = 1, urun_p = 0, cts = 0, sync = 0;
    logic amode = 0, xtal = 0;
    logic ie_b = 0, ie_u = 0, ie_c = 0, ie_s = 0;
    logic c_es = 0, c_uc = 0, c_ab = 0;
    logic [7:0] stat;
    logic irq;

    always #4 clk = ~clk;

    xstat_latch u0 (
        .clk(clk), .rst_n(rst_n), .brk_lvl_i(brk), .tx_en_i(tx_en),
        .tx_urun_i(urun_p), .cts_pin_i(cts), .sync_pin_i(sync),
        .async_mode_i(amode), .xtal_sel_i(xtal), .ie_brk_i(ie_b),
        .ie_urun_i(ie_u), .ie_cts_i(ie_c), .ie_sync_i(ie_s),
        .cmd_es_clr_i(c_es), .cmd_urun_clr_i(c_uc), .cmd_abort_i(c_ab),
        .stat_o(stat), .irq_o(irq)
    );

    typedef struct {
        logic [7:0] st;
        logic       rq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   nchk = 0;
    int   nerr = 0;
    bit   done = 0;

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            nchk++;
            if (stat !== e.st || irq !== e.rq) begin
                nerr++;
                $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                         e.tag, stat, irq, e.st, e.rq);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_(input logic [7:0] st, input logic rq, input string tag);
        exp_t e;
        e.st = st; e.rq = rq; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic release_es();
        c_es = 1; step(1); c_es = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        expect_(8'h40, 0, "R1 reset state");
        c_uc = 1; step(1); c_uc = 0;
        expect_(8'h00, 0, "R4 clear strobe");
        // R8 live level, no request
        cts = 1; step(1);
        expect_(8'h20, 0, "R8 live cts high");
        cts = 0; step(1);
        expect_(8'h00, 0, "R8 live cts low");
        ie_b = 1; ie_u = 1; ie_c = 1; ie_s = 1;
        step(1);
        // R6 latch and raise
        cts = 1; step(1);
        expect_(8'h20, 1, "R6 cts change raises");
        cts = 0; step(1); cts = 1; step(1); cts = 0; step(1);
        expect_(8'h20, 1, "R2 frozen after three toggles");
        release_es();
        expect_(8'h00, 1, "R7 odd toggles re-raise");
        release_es();
        expect_(8'h00, 0, "R10 release drops request");
        cts = 1; step(1);
        expect_(8'h20, 1, "R6 second raise");
        cts = 0; step(1); cts = 1; step(1);
        release_es();
        expect_(8'h20, 0, "R7 even toggles no raise");
        cts = 0; step(1);
        release_es();
        expect_(8'h00, 0, "R7 cleanup");
        // R3 break both edges while pending
        sync = 1; step(1);
        expect_(8'h10, 1, "R6 sync change raises");
        brk = 1; step(1);
        expect_(8'h90, 1, "R3 break live while pending");
        brk = 0; step(1);
        release_es();
        expect_(8'h10, 1, "R3 edge while pending re-raises");
        release_es();
        expect_(8'h10, 0, "R3 drained");
        brk = 1; step(1);
        release_es();
        expect_(8'h90, 0, "R3 rise served");
        brk = 0; step(1);
        expect_(8'h10, 1, "R3 fall raises");
        release_es();
        brk = 1; step(1);
        c_es = 1; brk = 0; step(1); c_es = 0;
        expect_(8'h10, 1, "R3 edge in release cycle");
        release_es();
        expect_(8'h10, 0, "R3 same cycle drained");
        // R5 underrun rise
        urun_p = 1; step(1); urun_p = 0; step(1);
        expect_(8'h50, 1, "R5 underrun rise raises");
        release_es();
        c_uc = 1; step(1); c_uc = 0; step(1);
        expect_(8'h10, 0, "R5 fall raises nothing");
        tx_en = 0; step(1); tx_en = 1; step(1);
        expect_(8'h50, 1, "R4 tx disable sets");
        release_es();
        c_uc = 1; step(1); c_uc = 0;
        c_ab = 1; step(1); c_ab = 0; step(1);
        expect_(8'h50, 1, "R4 abort sets");
        release_es();
        c_ab = 1; c_uc = 1; step(1); c_ab = 0; c_uc = 0; step(1);
        expect_(8'h50, 0, "R4 set wins over clear");
        // R9 forced sync
        amode = 1; xtal = 1; step(1);
        expect_(8'h40, 0, "R9 sync forced to zero");
        sync = 0; step(1); sync = 1; step(2);
        expect_(8'h40, 0, "R9 no request when forced");
        amode = 0; step(1);
        expect_(8'h50, 0, "R9 force lifted");
        release_es();
        expect_(8'h50, 0, "R10 release with nothing pending");
        step(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule